// File: doc/BRIEF.md
# I2C Eight-Pin Port Expander

This block gives a host on a two-wire serial bus control of eight general-purpose pins. It acts as a bus target at address `0100` followed by three strap inputs. Each pin has four storage bits: an input latch, an output value, a read-polarity flip and a direction bit. A host transaction starts with a command byte that picks one of the four banks. Data bytes that follow are written to that bank, and a read transaction returns the bank picked last.

The bus lines reach the block as plain inputs, sampled on the system clock. It drives the data line only through a pull-low enable. The pins are modelled as a sampled input vector, an output value vector and an output enable vector. An active-low interrupt tells the host that an input pin no longer matches the value it last read from the input bank.

Top module: `i2c_io_expander`

## Requirements
- R1: While `rst` is high and afterwards until a write, the output bank is 0xFF, the polarity bank 0x00 and the direction bank 0xFF. So `pin_oe_o` is 0x00, `pin_o` is 0xFF and `sda_pull_o` is 0. The input latch takes `pin_i` during reset, so `irq_n_o` is 1 with steady pins.
- R2: A bank changes only when a whole data byte has been taken in, on the falling SCL edge of its eighth bit. A byte cut short by a stop leaves every bank unchanged.
- R3: Direction bit 0 drives the pin, with `pin_oe_o[i]`=1 and `pin_o[i]` equal to the output bank bit. Direction bit 1 makes the pin an input, with `pin_oe_o[i]`=0.
- R4: The first byte after a start holds a 7-bit address, MSB first, followed by R/W (1 = read). The address matches when it equals `0100` followed by `addr_strap_i`. On a match the block pulls SDA low through the ninth clock. On a mismatch it never pulls SDA low and ignores the bytes that follow, up to the next start.
- R5: The first data byte of a write is a command. Its bits [1:0] pick the bank: 0 is input, 1 is output, 2 is polarity and 3 is direction. Bits [7:2] are ignored. Each received data byte is acknowledged.
- R6: A read sends the picked bank MSB first. The input bank returns `pin_i` XOR the polarity bank, sampled as each byte starts. The input latch takes that same sample.
- R7: All data bytes of a write go to the same bank, so the last byte wins. A read returns one byte for each byte the host acknowledges. A host NACK ends the send, and SDA is released.
- R8: A data byte written while the input bank is picked changes no bank.
- R9: `irq_n_o` is 0 while some pin whose direction bit is 1 differs from the input latch. It returns to 1 when the input bank is read or when the pin goes back to its latched value. Pins set as outputs never affect it.
- R10: A start condition restarts the address phase from any state, even in the middle of a byte. A stop returns the block to idle.
- R11: The bank choice is kept across transactions. A read without a new command returns the bank picked last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | When 1, the block pulls the data line low |
| addr_strap_i | input | 3 | Low three bits of the target address |
| pin_i | input | 8 | Sampled pin levels |
| pin_o | output | 8 | Output value for each pin |
| pin_oe_o | output | 8 | Output enable for each pin |
| irq_n_o | output | 1 | Active-low input-change flag |

## Verification
A wrong bit count or a wrong state in the bus engine shows up on `sda_pull_o` within one SCL period. The acknowledge then lands on the wrong clock, or the data line is held during the host's own bit, or a NACK leaves the line held. A wrong bank choice or a wrong write strobe shows on `pin_o` or `pin_oe_o` a few system clocks after the eighth SCL fall of the byte, or in the next read-back. A stale input latch shows on `irq_n_o` as soon as a pin moves or a read ends.

// File: rtl/exp_pkg.sv
package exp_pkg;

    localparam int PORT_W   = 8;
    localparam int STRAP_W  = 3;
    localparam int DEV_W    = 7;
    localparam int BITCNT_W = 4;
    localparam logic [DEV_W-STRAP_W-1:0] DEV_HI = 4'b0100;

    typedef enum logic [1:0] {
        SEL_IN  = 2'd0,
        SEL_OUT = 2'd1,
        SEL_POL = 2'd2,
        SEL_CFG = 2'd3
    } bank_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK
    } tgt_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } line_ev_t;

    typedef struct packed {
        logic              wr;
        logic              cmd;
        logic              rd;
        logic [PORT_W-1:0] data;
    } bank_req_t;

    function automatic logic [DEV_W-1:0] dev_addr(input logic [STRAP_W-1:0] strap);
        return {DEV_HI, strap};
    endfunction

endpackage

// File: rtl/exp_line_cond.sv
module exp_line_cond
    import exp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);

    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] scl_sh;
    logic [SH_W-1:0] sda_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[SH_W-2:0], scl_i};
            sda_sh <= {sda_sh[SH_W-2:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_sh[SH_W-2];
    assign scl_old = scl_sh[SH_W-1];
    assign sda_now = sda_sh[SH_W-2];
    assign sda_old = sda_sh[SH_W-1];

    always_comb begin
        ev_o.start = scl_now & scl_old & sda_old & ~sda_now;
        ev_o.stop  = scl_now & scl_old & ~sda_old & sda_now;
        ev_o.rise  = scl_now & ~scl_old;
        ev_o.fall  = ~scl_now & scl_old;
        ev_o.sda   = sda_now;
    end

    a_r10_conditions_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_o.start, ev_o.stop, ev_o.rise, ev_o.fall}));

endmodule

// File: rtl/exp_i2c_target.sv
module exp_i2c_target
    import exp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev_i,
    input  logic [DEV_W-1:0]  dev_addr_i,
    input  logic [PORT_W-1:0] rd_byte_i,
    output bank_req_t         req_o,
    output logic              sda_pull_o
);

    localparam logic [BITCNT_W-1:0] LAST_RX = BITCNT_W'(PORT_W);
    localparam logic [BITCNT_W-1:0] LAST_TX = BITCNT_W'(PORT_W - 1);

    tgt_state_e          state_q;
    logic [BITCNT_W-1:0] bit_cnt_q;
    logic [PORT_W-1:0]   rx_q;
    logic [PORT_W-1:0]   tx_q;
    logic                rw_q;
    logic                addr_phase_q;
    logic                cmd_due_q;
    logic                nack_q;
    logic                wr_q, cmd_q, rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            bit_cnt_q    <= '0;
            rx_q         <= '0;
            tx_q         <= '1;
            rw_q         <= 1'b0;
            addr_phase_q <= 1'b0;
            cmd_due_q    <= 1'b0;
            nack_q       <= 1'b1;
            wr_q         <= 1'b0;
            cmd_q        <= 1'b0;
            rd_q         <= 1'b0;
        end else begin
            wr_q  <= 1'b0;
            cmd_q <= 1'b0;
            rd_q  <= 1'b0;
            if (ev_i.start) begin
                state_q      <= ST_RX;
                bit_cnt_q    <= '0;
                addr_phase_q <= 1'b1;
            end else if (ev_i.stop) begin
                state_q <= ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_RX: begin
                        if (ev_i.rise) begin
                            rx_q      <= {rx_q[PORT_W-2:0], ev_i.sda};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end else if (ev_i.fall && bit_cnt_q == LAST_RX) begin
                            if (addr_phase_q) begin
                                addr_phase_q <= 1'b0;
                                if (rx_q[PORT_W-1:1] == dev_addr_i) begin
                                    state_q   <= ST_RACK;
                                    rw_q      <= rx_q[0];
                                    cmd_due_q <= ~rx_q[0];
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end else begin
                                state_q <= ST_RACK;
                                if (cmd_due_q) begin
                                    cmd_q     <= 1'b1;
                                    cmd_due_q <= 1'b0;
                                end else begin
                                    wr_q <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev_i.fall) begin
                            bit_cnt_q <= '0;
                            if (rw_q) begin
                                state_q <= ST_TX;
                                tx_q    <= rd_byte_i;
                                rd_q    <= 1'b1;
                            end else begin
                                state_q <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev_i.fall) begin
                            tx_q      <= {tx_q[PORT_W-2:0], 1'b1};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                            if (bit_cnt_q == LAST_TX) state_q <= ST_TACK;
                        end
                    end
                    ST_TACK: begin
                        if (ev_i.rise) begin
                            nack_q <= ev_i.sda;
                        end else if (ev_i.fall) begin
                            bit_cnt_q <= '0;
                            if (!nack_q) begin
                                state_q <= ST_TX;
                                tx_q    <= rd_byte_i;
                                rd_q    <= 1'b1;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull_o = (state_q == ST_RACK) || (state_q == ST_TX && !tx_q[PORT_W-1]);

    always_comb begin
        req_o.wr   = wr_q;
        req_o.cmd  = cmd_q;
        req_o.rd   = rd_q;
        req_o.data = rx_q;
    end

    a_r10_release_on_stop: assert property (@(posedge clk) disable iff (rst)
        ev_i.stop |=> !sda_pull_o);
    a_r10_start_restarts: assert property (@(posedge clk) disable iff (rst)
        ev_i.start |=> (state_q == ST_RX && bit_cnt_q == '0 && addr_phase_q));
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_o.wr, req_o.cmd, req_o.rd}));
    a_r2_bitcnt_bounded: assert property (@(posedge clk) disable iff (rst)
        bit_cnt_q <= LAST_RX);
    a_r7_nack_releases: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TACK && ev_i.fall && nack_q && !ev_i.start) |=> !sda_pull_o);

endmodule

// File: rtl/exp_pin_bank.sv
module exp_pin_bank
    import exp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bank_req_t         req_i,
    input  logic [PORT_W-1:0] pin_i,
    output logic [PORT_W-1:0] rd_byte_o,
    output logic [PORT_W-1:0] pin_o,
    output logic [PORT_W-1:0] pin_oe_o,
    output logic              irq_n_o
);

    bank_sel_e         sel_q;
    logic [PORT_W-1:0] in_q;
    logic [PORT_W-1:0] out_q;
    logic [PORT_W-1:0] pol_q;
    logic [PORT_W-1:0] cfg_q;
    logic [PORT_W-1:0] changed;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= SEL_IN;
            in_q  <= pin_i;
            out_q <= '1;
            pol_q <= '0;
            cfg_q <= '1;
        end else begin
            if (req_i.cmd) sel_q <= bank_sel_e'(req_i.data[1:0]);
            if (req_i.wr) begin
                unique case (sel_q)
                    SEL_OUT: out_q <= req_i.data;
                    SEL_POL: pol_q <= req_i.data;
                    SEL_CFG: cfg_q <= req_i.data;
                    default: ;
                endcase
            end
            if (req_i.rd && sel_q == SEL_IN) in_q <= pin_i;
        end
    end

    always_comb begin
        unique case (sel_q)
            SEL_IN:  rd_byte_o = pin_i ^ pol_q;
            SEL_OUT: rd_byte_o = out_q;
            SEL_POL: rd_byte_o = pol_q;
            default: rd_byte_o = cfg_q;
        endcase
    end

    for (genvar g = 0; g < PORT_W; g++) begin : g_pin
        assign pin_o[g]    = out_q[g];
        assign pin_oe_o[g] = ~cfg_q[g];
        assign changed[g]  = cfg_q[g] & (pin_i[g] ^ in_q[g]);
    end

    assign irq_n_o = ~|changed;

    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !req_i.wr |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));
    a_r8_input_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (req_i.wr && sel_q == SEL_IN) |=> ($stable(pin_o) && $stable(pin_oe_o) && $stable(pol_q)));
    a_r9_read_clears_irq: assert property (@(posedge clk) disable iff (rst)
        (req_i.rd && sel_q == SEL_IN) |=> (irq_n_o || !$stable(pin_i)));
    a_r11_sel_holds: assert property (@(posedge clk) disable iff (rst)
        !req_i.cmd |=> $stable(sel_q));

endmodule

// File: rtl/i2c_io_expander.sv
module i2c_io_expander
    import exp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [STRAP_W-1:0] addr_strap_i,
    input  logic [PORT_W-1:0] pin_i,
    output logic [PORT_W-1:0] pin_o,
    output logic [PORT_W-1:0] pin_oe_o,
    output logic              irq_n_o
);

    line_ev_t          line_ev;
    bank_req_t         bank_req;
    logic [PORT_W-1:0] rd_byte;

    exp_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (line_ev)
    );

    exp_i2c_target u_tgt (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (line_ev),
        .dev_addr_i (dev_addr(addr_strap_i)),
        .rd_byte_i  (rd_byte),
        .req_o      (bank_req),
        .sda_pull_o (sda_pull_o)
    );

    exp_pin_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .req_i     (bank_req),
        .pin_i     (pin_i),
        .rd_byte_o (rd_byte),
        .pin_o     (pin_o),
        .pin_oe_o  (pin_oe_o),
        .irq_n_o   (irq_n_o)
    );

    a_r3_outputs_only_change_on_write: assert property (@(posedge clk) disable iff (rst)
        !$past(bank_req.wr) |-> ($stable(pin_o) && $stable(pin_oe_o)));

endmodule

// File: tb/i2c_io_expander_tb_top.sv
`timescale 1ns/1ps
module i2c_io_expander_tb_top;

    localparam int HB = 12;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [6:0] ME = {4'b0100, STRAP};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [7:0] pin_in = 8'h3C;
    logic       sda_pull;
    logic [7:0] pin_o, pin_oe;
    logic       irq_n;
    wire        sda_line = sda_m & ~sda_pull;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    i2c_io_expander dut_i (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_pull_o   (sda_pull),
        .addr_strap_i (STRAP),
        .pin_i        (pin_in),
        .pin_o        (pin_o),
        .pin_oe_o     (pin_oe),
        .irq_n_o      (irq_n)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(HB);
        scl_m = 1'b1; wt(HB);
        sda_m = 1'b0; wt(HB);
        scl_m = 1'b0; wt(HB);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(HB);
        scl_m = 1'b1; wt(HB);
        sda_m = 1'b1; wt(HB);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wt(HB);
        scl_m = 1'b1; wt(HB);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wt(HB);
        scl_m = 1'b1; wt(HB / 2);
        ack = !sda_line;
        wt(HB / 2);
        scl_m = 1'b0; wt(HB);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        sda_m = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            wt(HB);
            scl_m = 1'b1; wt(HB / 2);
            d = {d[6:0], sda_line};
            wt(HB / 2);
            scl_m = 1'b0;
        end
        sda_m = nack; wt(HB);
        scl_m = 1'b1; wt(HB);
        scl_m = 1'b0; wt(2);
        sda_m = 1'b1; wt(HB);
    endtask

    task automatic reg_write(input logic [7:0] cmd, input logic [7:0] val);
        logic a;
        bus_start();
        send_byte({ME, 1'b0}, a); chk("R4 addr ack", {7'd0, a}, 8'd1);
        send_byte(cmd, a);        chk("R5 cmd ack", {7'd0, a}, 8'd1);
        send_byte(val, a);        chk("R5 data ack", {7'd0, a}, 8'd1);
        bus_stop();
    endtask

    task automatic reg_read(input logic [7:0] cmd, output logic [7:0] d);
        logic a;
        bus_start();
        send_byte({ME, 1'b0}, a);
        send_byte(cmd, a);
        bus_start();
        send_byte({ME, 1'b1}, a); chk("R4 read addr ack", {7'd0, a}, 8'd1);
        recv_byte(1'b1, d);
        bus_stop();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_o", pin_o, 8'hFF);
        chk("R1 irq_n", {7'd0, irq_n}, 8'd1);
        chk("R1 sda_pull", {7'd0, sda_pull}, 8'd0);
        reg_read(8'h03, d); chk("R1 cfg default", d, 8'hFF);
        reg_read(8'h02, d); chk("R1 pol default", d, 8'h00);
        reg_read(8'h01, d); chk("R1 out default", d, 8'hFF);
        reg_read(8'h00, d); chk("R6 input read", d, 8'h3C);
    endtask

    task automatic t_direction();
        logic [7:0] d;
        reg_write(8'h01, 8'h5A);
        reg_write(8'h03, 8'hF0);
        wt(4);
        chk("R3 pin_o", pin_o, 8'h5A);
        chk("R3 pin_oe", pin_oe, 8'h0F);
        reg_read(8'h03, d); chk("R6 cfg readback", d, 8'hF0);
        reg_read(8'h01, d); chk("R6 out readback", d, 8'h5A);
    endtask

    task automatic t_polarity();
        logic [7:0] d;
        reg_write(8'h02, 8'h0F);
        reg_read(8'h00, d); chk("R6 input xor polarity", d, 8'h33);
        reg_read(8'h02, d); chk("R6 pol readback", d, 8'h0F);
        chk("R9 irq idle after read", {7'd0, irq_n}, 8'd1);
    endtask

    task automatic t_cmd_upper();
        reg_write(8'hFD, 8'hC3);
        wt(4);
        chk("R5 upper cmd bits ignored", pin_o, 8'hC3);
        chk("R5 cfg untouched", pin_oe, 8'h0F);
    endtask

    task automatic t_multi();
        logic a;
        logic [7:0] d0, d1;
        bus_start();
        send_byte({ME, 1'b0}, a);
        send_byte(8'h01, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a); chk("R7 third data ack", {7'd0, a}, 8'd1);
        bus_stop();
        wt(4);
        chk("R7 last byte wins", pin_o, 8'h33);
        bus_start();
        send_byte({ME, 1'b0}, a);
        send_byte(8'h03, a);
        bus_start();
        send_byte({ME, 1'b1}, a);
        recv_byte(1'b0, d0);
        recv_byte(1'b1, d1);
        chk("R7 read byte 0", d0, 8'hF0);
        chk("R7 read byte 1", d1, 8'hF0);
        chk("R7 released after nack", {7'd0, sda_pull}, 8'd0);
        bus_stop();
    endtask

    task automatic t_input_write();
        logic [7:0] d;
        reg_write(8'h00, 8'h99);
        wt(4);
        chk("R8 pin_o unchanged", pin_o, 8'h33);
        reg_read(8'h02, d); chk("R8 pol unchanged", d, 8'h0F);
        reg_read(8'h03, d); chk("R8 cfg unchanged", d, 8'hF0);
    endtask

    task automatic t_persist();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte({ME, 1'b1}, a);
        recv_byte(1'b1, d);
        bus_stop();
        chk("R11 last bank kept", d, 8'hF0);
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        send_byte({4'b0100, 3'b100, 1'b0}, a); chk("R4 no ack wrong addr", {7'd0, a}, 8'd0);
        send_byte(8'h01, a);                   chk("R4 no ack after miss", {7'd0, a}, 8'd0);
        send_byte(8'h00, a);
        bus_stop();
        wt(4);
        chk("R4 ignored bytes", pin_o, 8'h33);
    endtask

    task automatic t_partial();
        logic a;
        bus_start();
        send_byte({ME, 1'b0}, a);
        send_byte(8'h01, a);
        for (int i = 0; i < 5; i++) put_bit(1'b0);
        bus_stop();
        wt(4);
        chk("R2 partial byte dropped", pin_o, 8'h33);
    endtask

    task automatic t_restart();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte({ME, 1'b0}, a);
        send_byte(8'h02, a);
        for (int i = 0; i < 3; i++) put_bit(1'b1);
        bus_start();
        send_byte({ME, 1'b0}, a); chk("R10 addr after restart", {7'd0, a}, 8'd1);
        send_byte(8'h01, a);
        send_byte(8'hE7, a);
        bus_stop();
        wt(4);
        chk("R10 write after restart", pin_o, 8'hE7);
        reg_read(8'h02, d); chk("R10 pol untouched", d, 8'h0F);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        chk("R9 irq idle", {7'd0, irq_n}, 8'd1);
        pin_in = 8'h3D; wt(6);
        chk("R9 output pin ignored", {7'd0, irq_n}, 8'd1);
        pin_in = 8'hBD; wt(6);
        chk("R9 input change flags", {7'd0, irq_n}, 8'd0);
        pin_in = 8'h3D; wt(6);
        chk("R9 return clears", {7'd0, irq_n}, 8'd1);
        pin_in = 8'hBD; wt(6);
        chk("R9 flag again", {7'd0, irq_n}, 8'd0);
        reg_read(8'h00, d);
        chk("R6 input read after change", d, 8'hB2);
        chk("R9 read clears", {7'd0, irq_n}, 8'd1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        wt(5);
        rst = 1'b0;
        wt(5);
        t_reset();
        t_direction();
        t_polarity();
        t_cmd_upper();
        t_multi();
        t_input_write();
        t_persist();
        t_mismatch();
        t_partial();
        t_restart();
        t_irq();
        wt(10);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule